// File: doc/BRIEF.md
# Interrupt Countdown Timer

This block is the timer slice of a local interrupt controller. Software programs a start value, a clock divide setting and a timer entry (vector, mask and mode) through a small register port. The counter then steps down once per prescaled tick. When a step is due while the count is already zero, the timer expires and issues a one-cycle interrupt request carrying the 8-bit vector.

In periodic mode the count reloads from the start value on each expiry, so requests repeat every start+1 ticks. In one-shot mode the count stops at zero after a single expiry. Writing the start value restarts both the count and the prescaler phase. A start value of zero never produces an expiry. Masking the entry suppresses the request but leaves the count running.

Top module: `irq_countdown_timer`

## Requirements
- R1: After reset, address 0 (start value) reads 0, address 1 (divide) reads 0, address 2 (entry) reads 0x0001_0000 (masked), address 3 (current count) reads 0, and no request is raised.
- R2: A write to address 1 keeps only data bits 3, 1 and 0. Reading address 1 returns the write data AND 0xB.
- R3: The divide index is {bit3, bit1, bit0} of the divide register. The tick period is 2^((index+1) mod 8) clocks, so index 7 gives 1 clock, index 0 gives 2 and index 6 gives 128.
- R4: In the entry at address 2, bit 17 selects periodic mode, bit 16 masks the request and bits 7:0 hold the vector. All other bits read 0.
- R5: A write to address 0 loads the count with the written value and restarts the prescaler phase. The first decrement lands one tick period after the write edge.
- R6: In periodic mode with a start value N>0, the count reads N, N-1, …, 0 and then N again. An expiry occurs every N+1 ticks.
- R7: In one-shot mode with N>0, the count reaches 0 after N ticks and holds there. Exactly one expiry occurs, at tick N+1, and none follows.
- R8: With a start value of 0, no expiry occurs in either mode and the count reads 0.
- R9: While bit 16 of the entry is set, no request is raised, but counting continues.
- R10: An expiry raises irq_valid for exactly one cycle, registered on the edge that performs the expiring tick. irq_vector carries the entry vector in force at that edge, so a vector change takes effect at the next expiry.
- R11: A divide write made while counting takes effect from the next prescaled tick. The period already in progress completes with the old setting.
- R12: Writes to address 3 change no register, and the count continues undisturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register select (0 start, 1 divide, 2 entry, 3 count) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read register select, same map |
| rd_data | output | 32 | Combinational read data |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector accompanying the request |

## Verification
A register write lands on the edge that samples it, so the read data reflect it in the same cycle that follows. A count change from a tick is visible just after the edge on which the tick occurs. A request appears just after the edge that performs the expiring tick, with no further delay. The bench advances its behavioural model on each rising edge, using the inputs sampled there, and compares read data and request outputs at the following falling edge. Every cycle is therefore judged against the model state for that exact edge. Counting requests over windows then confirms the expiry totals for the periodic, one-shot, masked and zero-start cases.

// File: rtl/ict_pkg.sv
package ict_pkg;
   typedef enum logic [1:0] {
      SEL_INIT  = 2'd0,
      SEL_DIV   = 2'd1,
      SEL_ENTRY = 2'd2,
      SEL_CURR  = 2'd3
   } reg_sel_e;

   localparam int REG_W        = 32;
   localparam int SHIFT_W      = 3;
   localparam int VEC_W        = 8;
   localparam int PERIODIC_BIT = 17;
   localparam int MASK_BIT     = 16;

   // divide field: bits 3,1,0 of the register form a 3-bit index
   function automatic logic [SHIFT_W-1:0] div_index(input logic [3:0] raw);
      return {raw[3], raw[1:0]};
   endfunction

   function automatic logic [3:0] div_raw(input logic [SHIFT_W-1:0] idx);
      return {idx[2], 1'b0, idx[1:0]};
   endfunction
endpackage

// File: rtl/ict_prescaler.sv
module ict_prescaler #(
   parameter int SW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic [SW-1:0] div_idx,
   output logic          tick
);
   localparam int CW = (1 << SW) - 1;

   if (SW < 1 || SW > 4) begin : g_bad_sw
      $error("ict_prescaler: SW out of range");
   end

   logic [SW-1:0] shift_q;
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] limit;

   // limit has shift_q low bits set: period is 2**shift_q clocks
   for (genvar i = 0; i < CW; i++) begin : g_lim
      assign limit[i] = (SW'(i) < shift_q);
   end

   assign tick = (cnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         shift_q <= SW'(1);
      end else if (restart || tick) begin
         cnt_q   <= '0;
         shift_q <= div_idx + SW'(1);
      end else begin
         cnt_q   <= cnt_q + 1'b1;
      end
   end

   // R3: with a nonzero shift two ticks are never adjacent
   a_r3_tick_gap : assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (shift_q == '0 || !tick));
endmodule

// File: rtl/ict_counter.sv
module ict_counter #(
   parameter int COUNT_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [COUNT_W-1:0] load_val,
   input  logic [COUNT_W-1:0] reload_val,
   input  logic               tick,
   input  logic               periodic,
   output logic [COUNT_W-1:0] count,
   output logic               expire
);
   logic [COUNT_W-1:0] cnt_q;
   logic               armed_q;

   assign count  = cnt_q;
   assign expire = tick && armed_q && (cnt_q == '0) && !load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (load) begin
         cnt_q   <= load_val;
         armed_q <= |load_val;
      end else if (tick && armed_q) begin
         if (cnt_q == '0) begin
            if (periodic) cnt_q   <= reload_val;
            else          armed_q <= 1'b0;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
      end
   end

   a_r5_load_value : assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt_q == $past(load_val)));

   a_r6_periodic_reload : assert property (@(posedge clk) disable iff (!rst_n)
      (expire && periodic) |=> (cnt_q == $past(reload_val)));

   a_r7_halted_holds : assert property (@(posedge clk) disable iff (!rst_n)
      (!armed_q && !load) |=> $stable(cnt_q));
endmodule

// File: rtl/ict_regs.sv
module ict_regs
   import ict_pkg::*;
#(
   parameter int COUNT_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [1:0]         wr_addr,
   input  logic [REG_W-1:0]   wr_data,
   input  logic [1:0]         rd_addr,
   input  logic [COUNT_W-1:0] count,
   output logic [REG_W-1:0]   rd_data,
   output logic               load,
   output logic [COUNT_W-1:0] init_q,
   output logic [SHIFT_W-1:0] div_idx,
   output logic               periodic,
   output logic               masked,
   output logic [VEC_W-1:0]   vector
);
   logic [REG_W-1:0] entry_rd;
   logic             unused_wr_bits;

   assign unused_wr_bits = ^wr_data;
   assign load = wr_en && (wr_addr == SEL_INIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_q   <= '0;
         div_idx  <= '0;
         periodic <= 1'b0;
         masked   <= 1'b1;
         vector   <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            SEL_INIT:  init_q  <= wr_data[COUNT_W-1:0];
            SEL_DIV:   div_idx <= div_index(wr_data[3:0]);
            SEL_ENTRY: begin
               periodic <= wr_data[PERIODIC_BIT];
               masked   <= wr_data[MASK_BIT];
               vector   <= wr_data[VEC_W-1:0];
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      entry_rd               = '0;
      entry_rd[PERIODIC_BIT] = periodic;
      entry_rd[MASK_BIT]     = masked;
      entry_rd[VEC_W-1:0]    = vector;
   end

   always_comb begin
      case (rd_addr)
         SEL_INIT:  rd_data = REG_W'(init_q);
         SEL_DIV:   rd_data = REG_W'(div_raw(div_idx));
         SEL_ENTRY: rd_data = entry_rd;
         default:   rd_data = REG_W'(count);
      endcase
   end

   a_r12_curr_write_inert : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == SEL_CURR) |=>
         ($stable(init_q) && $stable(div_idx) && $stable(periodic) &&
          $stable(masked) && $stable(vector)));
endmodule

// File: rtl/irq_countdown_timer.sv
module irq_countdown_timer
   import ict_pkg::*;
#(
   parameter int COUNT_W = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic [1:0]  wr_addr,
   input  logic [31:0] wr_data,
   input  logic [1:0]  rd_addr,
   output logic [31:0] rd_data,
   output logic        irq_valid,
   output logic [7:0]  irq_vector
);
   if (COUNT_W < 2 || COUNT_W > REG_W) begin : g_bad_width
      $error("irq_countdown_timer: COUNT_W out of range");
   end

   logic               load;
   logic [COUNT_W-1:0] init_q;
   logic [COUNT_W-1:0] count;
   logic [SHIFT_W-1:0] div_idx;
   logic               periodic;
   logic               masked;
   logic [VEC_W-1:0]   vector;
   logic               tick;
   logic               expire;

   ict_regs #(.COUNT_W(COUNT_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .rd_addr  (rd_addr),
      .count    (count),
      .rd_data  (rd_data),
      .load     (load),
      .init_q   (init_q),
      .div_idx  (div_idx),
      .periodic (periodic),
      .masked   (masked),
      .vector   (vector)
   );

   ict_prescaler #(.SW(SHIFT_W)) u_presc (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (load),
      .div_idx (div_idx),
      .tick    (tick)
   );

   ict_counter #(.COUNT_W(COUNT_W)) u_count (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .load_val   (wr_data[COUNT_W-1:0]),
      .reload_val (init_q),
      .tick       (tick),
      .periodic   (periodic),
      .count      (count),
      .expire     (expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_valid  <= 1'b0;
         irq_vector <= '0;
      end else begin
         irq_valid <= expire && !masked;
         if (expire) irq_vector <= vector;
      end
   end

   a_r10_single_cycle : assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |=> !irq_valid);

   a_r9_mask_blocks : assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> !$past(masked));

   a_r10_vector_source : assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid |-> (irq_vector == $past(vector)));
endmodule

// File: tb/irq_countdown_timer_test.sv
`timescale 1ns/1ps
module irq_countdown_timer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [1:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic        irq_valid;
   logic [7:0]  irq_vector;

   always #2.5 clk = ~clk;

   irq_countdown_timer uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .irq_valid(irq_valid), .irq_vector(irq_vector)
   );

   int    checks = 0;
   int    fails = 0;
   int    pulses = 0;
   int    last_vec = 0;
   bit    finished = 0;
   string tag = "R1";

   longint m_init, m_d;
   int     m_phase, m_period, m_div, m_entry, m_vec;
   bit     m_pulse;

   function automatic int shift_for(int div);
      int idx = (div & 3) | ((div >> 1) & 4);
      return (idx + 1) & 7;
   endfunction

   function automatic longint model_count();
      if (m_init == 0) return 0;
      if (m_entry[17]) return m_init - (m_d % (m_init + 1));
      return (m_d >= m_init) ? 0 : m_init - m_d;
   endfunction

   function automatic longint model_read(int ra);
      case (ra)
         0: return m_init;
         1: return m_div;
         2: return m_entry & 32'h0003_00FF;
         default: return model_count();
      endcase
   endfunction

   task automatic check(bit ok, string t, longint act, longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", t, act, exp);
      end
   endtask

   task automatic model_reset();
      m_init = 0; m_d = 0; m_phase = 0; m_div = 0;
      m_period = 1 << shift_for(0);
      m_entry = 32'h0001_0000; m_pulse = 0; m_vec = 0;
   endtask

   task automatic model_edge(bit we, int wa, longint wd);
      m_pulse = 0;
      if (we && wa == 0) begin
         m_init = wd; m_d = 0; m_phase = 0;
         m_period = 1 << shift_for(m_div);
      end else begin
         m_phase++;
         if (m_phase == m_period) begin
            m_phase = 0;
            m_period = 1 << shift_for(m_div);
            m_d++;
            if (m_init > 0 &&
                ((m_entry[17] && (m_d % (m_init + 1)) == 0) ||
                 (!m_entry[17] && m_d == m_init + 1))) begin
               if (!m_entry[16]) begin
                  m_pulse = 1; m_vec = m_entry & 8'hFF;
               end
            end
         end
      end
      if (we && wa == 1) m_div = int'(wd) & 32'hB;
      if (we && wa == 2) m_entry = int'(wd);
   endtask

   task automatic step(bit we, int wa, logic [31:0] wd, int ra);
      wr_en = we; wr_addr = 2'(wa); wr_data = wd; rd_addr = 2'(ra);
      @(posedge clk);
      model_edge(we, wa, longint'(wd));
      @(negedge clk);
      check(rd_data == 32'(model_read(ra)), tag, rd_data, model_read(ra));
      check(irq_valid == m_pulse, tag, irq_valid, m_pulse);
      if (m_pulse) check(irq_vector == 8'(m_vec), tag, irq_vector, m_vec);
      if (irq_valid) begin pulses++; last_vec = irq_vector; end
      wr_en = 1'b0;
   endtask

   task automatic run(int n);
      for (int i = 0; i < n; i++) step(0, 0, 32'h0, 3);
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog actual=running expected=done");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset values on every address
      tag = "R1";
      check(irq_valid == 1'b0, "R1", irq_valid, 0);
      for (int a = 0; a < 4; a++) step(0, 0, 32'h0, a);

      // R2 and R3: divide field keeps bits 3,1,0; index 7 -> every clock
      tag = "R2";
      step(1, 1, 32'hFFFF_FFFF, 1);
      check(rd_data == 32'hB, "R2", rd_data, 32'hB);
      // R4: entry fields, periodic, unmasked, vector 0x42
      tag = "R4";
      step(1, 2, 32'hF002_5542, 2);
      check(rd_data == 32'h0002_0042, "R4", rd_data, 32'h0002_0042);

      // R5 and R6: periodic start value 3 at divide-by-1
      tag = "R5";
      step(1, 0, 32'd3, 3);
      check(rd_data == 32'd3, "R5", rd_data, 3);
      tag = "R6";
      pulses = 0;
      run(20);
      check(pulses == 5, "R6", pulses, 5);

      // R9: masked, counting goes on
      tag = "R9";
      step(1, 2, 32'h0003_0042, 3);
      pulses = 0;
      run(16);
      check(pulses == 0, "R9", pulses, 0);

      // R10: vector change takes effect at the next expiry
      tag = "R10";
      step(1, 2, 32'h0002_0055, 3);
      pulses = 0;
      run(8);
      check(pulses == 2, "R10", pulses, 2);
      check(last_vec == 8'h55, "R10", last_vec, 8'h55);

      // R7: one-shot, start 4, divide by 2
      tag = "R7";
      step(1, 0, 32'd0, 3);
      step(1, 2, 32'h0000_0077, 3);
      step(1, 1, 32'h0, 3);
      step(1, 0, 32'd4, 3);
      pulses = 0;
      run(40);
      check(pulses == 1, "R7", pulses, 1);
      check(rd_data == 32'd0, "R7", rd_data, 0);

      // R8: start value zero in both modes
      tag = "R8";
      step(1, 0, 32'd0, 3);
      pulses = 0;
      run(20);
      step(1, 2, 32'h0002_0077, 3);
      step(1, 0, 32'd0, 3);
      run(20);
      check(pulses == 0, "R8", pulses, 0);

      // R11: divide change mid-run (shift 1 -> shift 4)
      tag = "R11";
      step(1, 2, 32'h0002_0011, 3);
      step(1, 0, 32'd10, 3);
      run(5);
      step(1, 1, 32'h3, 3);
      pulses = 0;
      run(200);
      check(pulses >= 1, "R11", pulses, 1);

      // R12: writes to the count address are inert
      tag = "R12";
      step(1, 3, 32'h0000_1234, 3);
      run(10);
      step(0, 0, 32'h0, 0);
      check(rd_data == 32'd10, "R12", rd_data, 10);
      step(0, 0, 32'h0, 1);
      check(rd_data == 32'h3, "R12", rd_data, 3);

      // R3: index 6 -> 128 clocks per tick, one-shot start 2
      tag = "R3";
      step(1, 0, 32'd0, 3);
      step(1, 2, 32'h0000_0099, 3);
      step(1, 1, 32'hA, 3);
      step(1, 0, 32'd2, 3);
      pulses = 0;
      run(127);
      check(rd_data == 32'd2, "R3", rd_data, 2);
      run(1);
      check(rd_data == 32'd1, "R3", rd_data, 1);
      run(300);
      check(pulses == 1, "R3", pulses, 1);
      check(last_vec == 8'h99, "R3", last_vec, 8'h99);

      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule